// File: doc/BRIEF.md
# Erase-Block Lock Register File

This block keeps a small lock register for every erase block of a flash array and turns those registers, two hardware protection pins and an auto-increment programming mode input into the final permissions. The program/erase sequencer and the read path both rely on these permissions. Software reads and writes the registers by block index. Every register has three live bits:

| Bit | Meaning |
|-----|---------|
| 0 | write lock |
| 1 | freeze |
| 2 | read lock |

The freeze bit is sticky. Once it is set, the register ignores all further writes until reset.

The block produces four kinds of output:

- A vector with one write-permitted flag per block.
- A read-permitted flag for a queried block.
- A copy of the array's read data, forced to zero for a read-locked block.
- An operation-permit flag, captured when a program or erase operation starts. The sequencer keeps acting on that sampled value for the rest of the operation.

Two active-low pins add hardware protection. One pin covers the top (boot) block. The other pin covers every other block. Neither pin appears in the register readback. When the auto-increment mode input is high, software locks and the top-block pin are both bypassed.

Top module: `blk_lock_regs`

## Requirements
- R1: Register readback places write lock in bit 0, freeze in bit 1 and read lock in bit 2. Bits 7..3 always read 0, and writes to those bits are dropped.
- R2: After reset every implemented block reads 0x01: write-locked, not frozen, read-unlocked.
- R3: A register whose freeze bit is 1 ignores all writes. Only reset clears the freeze bit.
- R4: For a block whose read lock is 1 (outside auto-increment mode), `rd_perm` is 0 and `arr_rdata_o` is 0x00. Otherwise `arr_rdata_o` equals `arr_rdata_i`.
- R5: With both pins high and auto-increment mode off, `wr_perm[b]` is the inverse of block b's write-lock bit.
- R6: Block NBLK-1 is the top block. When `tbl_n` is low, `wr_perm[NBLK-1]` is 0. When `wp_n` is low, `wr_perm` of every other block is 0. Neither pin changes the register readback.
- R7: `op_allowed` takes the value of `wr_perm[op_idx]` at a clock edge where `op_start` is 1. It holds that value until the next `op_start`, so later lock writes do not change it. Its reset value is 0.
- R8: With `aai_mode` high, every `wr_perm` bit is 1 and every implemented block is read-permitted, whatever the lock bits and `tbl_n` say.
- R9: An index at or above NBLK reads 0x00 and ignores writes. It yields `rd_perm` 0, and an operation started on it gets `op_allowed` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_wr_en | input | 1 | register write strobe |
| reg_wr_idx | input | IDX_W | block index written |
| reg_wr_data | input | 8 | write data |
| reg_rd_idx | input | IDX_W | block index read back |
| reg_rd_data | output | 8 | readback of the indexed register |
| wp_n | input | 1 | low: protect all blocks except the top one |
| tbl_n | input | 1 | low: protect the top block |
| aai_mode | input | 1 | auto-increment programming mode |
| wr_perm | output | NBLK | per-block write permission |
| op_start | input | 1 | program/erase operation begins |
| op_idx | input | IDX_W | block addressed by the operation |
| op_allowed | output | 1 | permission sampled at operation start |
| rd_q_idx | input | IDX_W | block addressed by an array read |
| rd_perm | output | 1 | read permitted for `rd_q_idx` |
| arr_rdata_i | input | 8 | data from the array |
| arr_rdata_o | output | 8 | read data after gating |

## Verification
Random register writes are mixed with occasional freeze writes, random pin levels and short spells of auto-increment mode. Each kind of stimulus tells apart a different failure:

- Freeze writes separate a sticky freeze from a merely stored one.
- Random pin levels expose protection that leaks into readback or reaches the wrong block.
- Auto-increment spells catch a bypass that forgets the top-block pin.

Directed cases cover the remaining points:

- Reset values.
- Out-of-range indices.
- A lock written just after an operation started, which shows whether the permit is sampled or followed live.

// File: rtl/blk_lock_regs.sv
module blk_lock_regs #(
  parameter int NBLK  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [IDX_W-1:0] reg_wr_idx,
  input  logic [7:0]       reg_wr_data,
  input  logic [IDX_W-1:0] reg_rd_idx,
  output logic [7:0]       reg_rd_data,
  input  logic             wp_n,
  input  logic             tbl_n,
  input  logic             aai_mode,
  output logic [NBLK-1:0]  wr_perm,
  input  logic             op_start,
  input  logic [IDX_W-1:0] op_idx,
  output logic             op_allowed,
  input  logic [IDX_W-1:0] rd_q_idx,
  output logic             rd_perm,
  input  logic [7:0]       arr_rdata_i,
  output logic [7:0]       arr_rdata_o
);
  localparam int TOP = NBLK - 1;

  logic [NBLK-1:0] wlk, frz, rlk, wsel;
  logic unused_rsvd;

  assign unused_rsvd = ^reg_wr_data[7:3];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign wsel[b] = reg_wr_en && (reg_wr_idx == IDX_W'(b)) && !frz[b];
    if (b == TOP) begin : g_top
      assign wr_perm[b] = aai_mode | (~wlk[b] & tbl_n);
    end else begin : g_rest
      assign wr_perm[b] = aai_mode | (~wlk[b] & wp_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlk <= '1;
      frz <= '0;
      rlk <= '0;
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (wsel[b]) begin
          wlk[b] <= reg_wr_data[0];
          frz[b] <= reg_wr_data[1];
          rlk[b] <= reg_wr_data[2];
        end
      end
    end
  end

  logic op_perm_now;

  always_comb begin
    reg_rd_data = 8'h00;
    rd_perm     = 1'b0;
    op_perm_now = 1'b0;
    for (int b = 0; b < NBLK; b++) begin
      if (reg_rd_idx == IDX_W'(b)) reg_rd_data = {5'b0, rlk[b], frz[b], wlk[b]};
      if (rd_q_idx == IDX_W'(b))   rd_perm     = aai_mode | ~rlk[b];
      if (op_idx == IDX_W'(b))     op_perm_now = wr_perm[b];
    end
  end

  assign arr_rdata_o = rd_perm ? arr_rdata_i : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        op_allowed <= 1'b0;
    else if (op_start) op_allowed <= op_perm_now;
  end
endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
  parameter int NBLK  = 32,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [IDX_W-1:0] reg_wr_idx,
  input logic [7:0]       reg_wr_data,
  input logic [IDX_W-1:0] reg_rd_idx,
  input logic [7:0]       reg_rd_data,
  input logic             wp_n,
  input logic             tbl_n,
  input logic             aai_mode,
  input logic [NBLK-1:0]  wr_perm,
  input logic             op_start,
  input logic [IDX_W-1:0] op_idx,
  input logic             op_allowed,
  input logic [IDX_W-1:0] rd_q_idx,
  input logic             rd_perm,
  input logic [7:0]       arr_rdata_i,
  input logic [7:0]       arr_rdata_o
);
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[7:3] == 5'b0);

  a_r3_frozen_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[1] && reg_wr_en && reg_wr_idx == reg_rd_idx)
      |=> (reg_rd_idx != $past(reg_rd_idx) || reg_rd_data == $past(reg_rd_data)));

  a_r4_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_perm |-> arr_rdata_o == 8'h00);

  a_r6_top_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!aai_mode && !tbl_n) |-> !wr_perm[NBLK-1]);

  a_r6_rest_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!aai_mode && !wp_n) |-> wr_perm[NBLK-2:0] == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_start |=> $stable(op_allowed));

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    aai_mode |-> &wr_perm);

  a_r9_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_rd_idx) >= NBLK) |-> reg_rd_data == 8'h00);
endmodule

bind blk_lock_regs blk_lock_chk #(.NBLK(NBLK), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_blk_lock_regs.sv
module tb_blk_lock_regs;
  localparam int NBLK  = 32;
  localparam int IDX_W = 6;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, wp_n = 1, tbl_n = 1, aai_mode = 0, op_start = 0;
  logic [IDX_W-1:0] reg_wr_idx = 0, reg_rd_idx = 0, op_idx = 0, rd_q_idx = 0;
  logic [7:0] reg_wr_data = 0, arr_rdata_i = 0, reg_rd_data, arr_rdata_o;
  logic [NBLK-1:0] wr_perm;
  logic op_allowed, rd_perm;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [2:0] m_lk [NBLK];
  logic m_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_regs #(.NBLK(NBLK), .IDX_W(IDX_W)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e_rd(logic [IDX_W-1:0] i);
    return (int'(i) < NBLK) ? {5'b0, m_lk[i]} : 8'h00;
  endfunction

  function automatic logic e_wp(int b);
    if (aai_mode) return 1'b1;
    return ~m_lk[b][0] & ((b == NBLK-1) ? tbl_n : wp_n);
  endfunction

  function automatic logic e_rp(logic [IDX_W-1:0] i);
    return (int'(i) < NBLK) && (aai_mode || !m_lk[i][2]);
  endfunction

  task automatic check_all();
    logic [NBLK-1:0] ev;
    #1;
    for (int b = 0; b < NBLK; b++) ev[b] = e_wp(b);
    chk("R1 readback", reg_rd_data, e_rd(reg_rd_idx));
    chk("R5 R6 R8 wr_perm", wr_perm, ev);
    chk("R4 rd_perm", rd_perm, e_rp(rd_q_idx));
    chk("R4 gated data", arr_rdata_o, e_rp(rd_q_idx) ? arr_rdata_i : 8'h00);
    chk("R7 op_allowed", op_allowed, m_op);
  endtask

  task automatic step();
    @(posedge clk);
    if (op_start) m_op = (int'(op_idx) < NBLK) ? e_wp(int'(op_idx)) : 1'b0;
    if (reg_wr_en && int'(reg_wr_idx) < NBLK && !m_lk[reg_wr_idx][1])
      m_lk[reg_wr_idx] = reg_wr_data[2:0];
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk);
    for (int b = 0; b < NBLK; b++) m_lk[b] = 3'b001;
    m_op = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(int idx, logic [7:0] d);
    reg_wr_en = 1; reg_wr_idx = IDX_W'(idx); reg_wr_data = d;
    step();
    reg_wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    for (int b = 0; b < NBLK; b++) begin
      reg_rd_idx = IDX_W'(b); #1;
      chk("R2 reset value", reg_rd_data, 8'h01);
    end
    chk("R7 op_allowed reset", op_allowed, 1'b0);

    wr(3, 8'hFF);
    reg_rd_idx = 3; #1;
    chk("R1 reserved dropped", reg_rd_data, 8'h07);
    wr(3, 8'h00);
    reg_rd_idx = 3; #1;
    chk("R3 frozen write ignored", reg_rd_data, 8'h07);
    rd_q_idx = 3; arr_rdata_i = 8'hA5; #1;
    chk("R4 locked read zero", arr_rdata_o, 8'h00);
    do_reset();
    reg_rd_idx = 3; #1;
    chk("R3 reset clears freeze", reg_rd_data, 8'h01);

    wr(40, 8'h06);
    reg_rd_idx = 40; rd_q_idx = 40; #1;
    chk("R9 unused index reads zero", reg_rd_data, 8'h00);
    chk("R9 unused index no read", rd_perm, 1'b0);

    wr(NBLK-1, 8'h00);
    wr(5, 8'h00);
    tbl_n = 0; reg_rd_idx = IDX_W'(NBLK-1); #1;
    chk("R6 top pin protects", wr_perm[NBLK-1], 1'b0);
    chk("R6 pin hidden in readback", reg_rd_data, 8'h00);
    chk("R6 top pin spares others", wr_perm[5], 1'b1);
    aai_mode = 1; #1;
    chk("R8 bypass all", wr_perm, {NBLK{1'b1}});
    aai_mode = 0; tbl_n = 1; wp_n = 0; #1;
    chk("R6 wp pin protects", wr_perm[5], 1'b0);
    chk("R6 wp pin spares top", wr_perm[NBLK-1], 1'b1);
    wp_n = 1;

    op_start = 1; op_idx = 5; step(); op_start = 0;
    chk("R7 sampled allowed", op_allowed, 1'b1);
    wr(5, 8'h01);
    #1; chk("R7 later lock no effect", op_allowed, 1'b1);
    op_start = 1; op_idx = 50; step(); op_start = 0;
    chk("R9 unused op denied", op_allowed, 1'b0);

    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 499) do_reset();
      reg_wr_en   = ($urandom % 3) == 0;
      reg_wr_idx  = IDX_W'(($urandom % 4 == 0) ? $urandom : $urandom % NBLK);
      reg_wr_data = 8'($urandom);
      if ($urandom % 10 != 0) reg_wr_data[1] = 1'b0;
      reg_rd_idx  = IDX_W'(($urandom % 8 == 0) ? $urandom : $urandom % NBLK);
      rd_q_idx    = IDX_W'($urandom % NBLK);
      op_idx      = IDX_W'($urandom % NBLK);
      op_start    = ($urandom % 4) == 0;
      wp_n        = ($urandom % 4) != 0;
      tbl_n       = ($urandom % 4) != 0;
      aai_mode    = ($urandom % 10) == 0;
      arr_rdata_i = 8'($urandom);
      check_all();
      step();
    end
    reg_wr_en = 0; op_start = 0;
    check_all();
    finish_run();
  end
endmodule